// File: doc/BRIEF.md
# Boot-Window Flash Security Controller

This block sits between a processor, a debug port and a flash controller. It keeps track of a fixed boot window that follows every reset. It also owns a single security bit that can only be set. Every flash operation request is checked against these two pieces of state. The block answers each request with either a grant, which carries a copy of the request towards the flash controller, or a deny, which is a one-cycle error pulse and produces no flash strobe.

During the boot window the debug port is held off, and the processor's early code is expected to set the security bit. Once the bit is set, the debug port may only perform a bulk erase of the whole flash. Writes and page erases that target page zero are refused for every requester. The bit can be removed only by a reset. A global erase on its own leaves the bit set. The intended way to remove security is therefore a global erase followed by a chip reset.

Top module: `flash_guard_top`

## Requirements
- R1: After reset is released, `boot_phase` is high for exactly `BOOT_CYCLES` (default 60) clock cycles. It then stays low until the next reset, because the cycle counter saturates.
- R2: `dbg_enable` is low while `boot_phase` is high and high once the boot window has ended.
- R3: `secure` is 0 after reset. A cycle with `sec_wr_en`=1 and `sec_wr_data`=1 sets it, and the new value is visible after that clock edge. Writing `sec_wr_data`=0 has no effect whether the bit is 0 or 1.
- R4: Once `secure` is set, it stays set until reset. A granted global erase does not clear it.
- R5: A debug-port request (`req_src`=1) made while `boot_phase` is high is denied, whatever its kind or page.
- R6: While `secure` is 1, a debug-port request is granted only for a global erase (`req_op`=2). Write (0), page erase (1) and read (3) from the debug port are denied.
- R7: While `secure` is 1, a write (`req_op`=0) or page erase (`req_op`=1) whose `req_page` is 0 is denied for both requesters. The same operations on any other page are granted to the processor (`req_src`=0).
- R8: While `secure` is 0, every request is granted except the debug-port requests covered by R5.
- R9: A request with `req_valid`=1 is answered one clock after it is sampled. The answer is a one-cycle pulse on exactly one of `req_grant` or `req_deny`. On a grant, `flash_src`, `flash_op` and `flash_page` hold the request fields. Neither pulse occurs without a request.
- R10: A request sampled in the same cycle as a security-bit write is judged by the security value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| sec_wr_en | input | 1 | Write strobe for the security bit |
| sec_wr_data | input | 1 | Data bit written to the security bit; only 1 takes effect |
| req_valid | input | 1 | A flash operation request is presented this cycle |
| req_src | input | 1 | Requester: 0 processor, 1 debug port |
| req_op | input | 2 | Kind: 0 write, 1 page erase, 2 global erase, 3 read |
| req_page | input | PAGE_W | Target page number |
| boot_phase | output | 1 | High during the boot window after reset |
| dbg_enable | output | 1 | Debug port may take control |
| secure | output | 1 | Current security bit |
| req_grant | output | 1 | One-cycle grant pulse; doubles as the flash strobe |
| req_deny | output | 1 | One-cycle error pulse for a refused request |
| flash_src | output | 1 | Requester of the granted operation |
| flash_op | output | 2 | Kind of the granted operation |
| flash_page | output | PAGE_W | Page of the granted operation |

## Verification
`boot_phase` and `dbg_enable` come straight from the cycle counter. The bench therefore samples them at each falling edge after reset release and expects the window to close after the sixtieth sample. A request driven at a falling edge is registered at the next rising edge. Its grant or deny is read at the falling edge that follows, and the falling edge after that must show both pulses low. A security-bit write follows the same timing: the bench reads `secure` half a cycle after the edge that captured the write. In the same cycle the bench checks the verdict on a request sent together with the write against the old bit value.

// File: rtl/flash_guard_pkg.sv
// Shared encodings for the flash security controller.
package flash_guard_pkg;
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_PERASE = 2'd1,
        OP_GERASE = 2'd2,
        OP_READ   = 2'd3
    } fg_op_e;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_DBG = 1'b1
    } fg_src_e;
endpackage

// File: rtl/fg_boot_timer.sv
// Boot window timer.
// Counts clock cycles from reset release and saturates at BOOT_CYCLES.
// boot_phase is high while fewer than BOOT_CYCLES cycles have elapsed.
// Assumes: synchronous active-low reset; BOOT_CYCLES >= 1.
module fg_boot_timer #(
    parameter int BOOT_CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    output logic boot_phase
);
    localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BOOT_CYCLES);

    logic [CNT_W-1:0] cycle_cnt;

    // Count elapsed cycles since reset, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cycle_cnt <= '0;
        else if (cycle_cnt != LIMIT)
            cycle_cnt <= cycle_cnt + 1'b1;
    end

    // Window is open until the limit is reached.
    always_comb boot_phase = (cycle_cnt < LIMIT);

    // R1
    window_stays_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_phase |=> !boot_phase);
    // R1
    count_never_past_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_cnt <= LIMIT);
endmodule

// File: rtl/fg_secure_bit.sv
// One-way security latch.
// Only a write of 1 changes the bit; it returns to 0 solely on reset.
// Assumes: synchronous active-low reset.
module fg_secure_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    output logic secure
);
    // Set-only register cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            secure <= 1'b0;
        else if (wr_en && wr_data)
            secure <= 1'b1;
    end

    // R4
    secure_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        secure |=> secure);
    // R3
    secure_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !secure ##1 secure |-> $past(wr_en) && $past(wr_data));
endmodule

// File: rtl/fg_access_check.sv
// Request permission check.
// Judges each request against the boot window and security bit, then
// registers a one-cycle grant (with request copy) or deny pulse.
// Assumes: request fields are valid when req_valid is high; the security
// value used is the registered one, before any write in the same cycle.
module fg_access_check
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_phase,
    input  logic              secure,
    input  logic              req_valid,
    input  logic              req_src,
    input  logic [1:0]        req_op,
    input  logic [PAGE_W-1:0] req_page,
    output logic              grant,
    output logic              deny,
    output logic              src_q,
    output logic [1:0]        op_q,
    output logic [PAGE_W-1:0] page_q
);
    fg_op_e  op;
    fg_src_e src;
    logic    page_zero;
    logic    refuse;

    // Decode the request and decide whether it must be refused.
    always_comb begin
        op        = fg_op_e'(req_op);
        src       = fg_src_e'(req_src);
        page_zero = (req_page == '0);
        refuse    = 1'b0;
        if (src == SRC_DBG && boot_phase)
            refuse = 1'b1;
        if (secure && src == SRC_DBG && op != OP_GERASE)
            refuse = 1'b1;
        if (secure && page_zero && (op == OP_WRITE || op == OP_PERASE))
            refuse = 1'b1;
    end

    // Register the verdict pulses and the granted request copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant  <= 1'b0;
            deny   <= 1'b0;
            src_q  <= 1'b0;
            op_q   <= 2'd0;
            page_q <= '0;
        end else begin
            grant <= req_valid && !refuse;
            deny  <= req_valid && refuse;
            if (req_valid && !refuse) begin
                src_q  <= req_src;
                op_q   <= req_op;
                page_q <= req_page;
            end
        end
    end

    // R9
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));
    // R9
    verdict_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || deny) |-> $past(req_valid));
    // R6
    secure_dbg_only_bulk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant && src_q && $past(secure) |-> op_q == 2'd2);
    // R7
    page0_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant && $past(secure) && page_q == '0 |-> op_q[1]);
    // R5
    no_dbg_in_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant && src_q |-> !$past(boot_phase));
endmodule

// File: rtl/flash_guard_top.sv
// Boot-window flash security controller top level.
// Ties the boot timer, the one-way security bit and the request checker
// together; debug enable follows the end of the boot window.
// Assumes: synchronous active-low reset on the processor clock.
module flash_guard_top #(
    parameter int BOOT_CYCLES = 60,
    parameter int PAGE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_wr_en,
    input  logic              sec_wr_data,
    input  logic              req_valid,
    input  logic              req_src,
    input  logic [1:0]        req_op,
    input  logic [PAGE_W-1:0] req_page,
    output logic              boot_phase,
    output logic              dbg_enable,
    output logic              secure,
    output logic              req_grant,
    output logic              req_deny,
    output logic              flash_src,
    output logic [1:0]        flash_op,
    output logic [PAGE_W-1:0] flash_page
);
    fg_boot_timer #(.BOOT_CYCLES(BOOT_CYCLES)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_phase (boot_phase)
    );

    fg_secure_bit i_secure (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sec_wr_en),
        .wr_data (sec_wr_data),
        .secure  (secure)
    );

    fg_access_check #(.PAGE_W(PAGE_W)) i_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_phase (boot_phase),
        .secure     (secure),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_op     (req_op),
        .req_page   (req_page),
        .grant      (req_grant),
        .deny       (req_deny),
        .src_q      (flash_src),
        .op_q       (flash_op),
        .page_q     (flash_page)
    );

    // Debug port may act only after the boot window.
    always_comb dbg_enable = !boot_phase;

    // R2
    dbg_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_enable != boot_phase);
endmodule

// File: tb/test_flash_guard_top.sv
module test_flash_guard_top;
    localparam int PW = 8;
    localparam int BOOT = 60;

    logic clk = 0, rst_n = 0;
    logic sec_wr_en = 0, sec_wr_data = 0;
    logic req_valid = 0, req_src = 0;
    logic [1:0] req_op = 0;
    logic [PW-1:0] req_page = 0;
    logic boot_phase, dbg_enable, secure, req_grant, req_deny, flash_src;
    logic [1:0] flash_op;
    logic [PW-1:0] flash_page;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    flash_guard_top #(.BOOT_CYCLES(BOOT), .PAGE_W(PW)) i_flash_guard_top (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected verdict: 1 = grant.
    function automatic int model(input int sec, input int boot, input int src,
                                 input int op, input int page);
        if (src == 1 && boot == 1) return 0;
        if (sec == 1 && src == 1 && op != 2) return 0;
        if (sec == 1 && page == 0 && (op == 0 || op == 1)) return 0;
        return 1;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_window();
        repeat (BOOT + 2) @(negedge clk);
    endtask

    // Drive at a falling edge, verdict read one full cycle later.
    task automatic do_req(input string tag, input int src, input int op,
                          input int page, input int sec, input int boot);
        int g;
        req_valid = 1; req_src = src[0]; req_op = op[1:0]; req_page = page[PW-1:0];
        @(negedge clk);
        req_valid = 0;
        g = model(sec, boot, src, op, page);
        chk({tag, " grant"}, int'(req_grant), g);
        chk({tag, " deny"}, int'(req_deny), 1 - g);
        if (g == 1) begin
            chk("R9 flash_src", int'(flash_src), src);
            chk("R9 flash_op", int'(flash_op), op);
            chk("R9 flash_page", int'(flash_page), page);
        end
        @(negedge clk);
        chk("R9 pulse width", int'(req_grant | req_deny), 0);
    endtask

    initial begin
        // Boot window timing, R1 and R2.
        do_reset();
        chk("R3 reset secure", int'(secure), 0);
        for (int i = 0; i < BOOT + 10; i++) begin
            chk("R1 boot_phase", int'(boot_phase), i < BOOT ? 1 : 0);
            chk("R2 dbg_enable", int'(dbg_enable), i < BOOT ? 0 : 1);
            @(negedge clk);
        end
        chk("R9 idle no pulse", int'(req_grant | req_deny), 0);

        // Requests during the boot window, R5.
        do_reset();
        for (int op = 0; op < 4; op++) begin
            do_req("R5 dbg in window", 1, op, 5, 0, 1);
            do_req("R8 cpu in window", 0, op, 0, 0, 1);
        end

        // Full sweep with security clear and set, R6 R7 R8.
        for (int sec = 0; sec < 2; sec++) begin
            do_reset();
            wait_window();
            if (sec == 1) begin
                sec_wr_en = 1; sec_wr_data = 1;
                @(negedge clk);
                sec_wr_en = 0;
                chk("R3 set", int'(secure), 1);
            end
            for (int src = 0; src < 2; src++)
                for (int op = 0; op < 4; op++)
                    for (int pg = 0; pg < 5; pg++)
                        do_req(sec == 1 ? (src == 1 ? "R6 sweep" : "R7 sweep") : "R8 sweep",
                               src, op, pg == 4 ? 255 : pg, sec, 0);
        end

        // Writing 0 does nothing, R3.
        do_reset();
        sec_wr_en = 1; sec_wr_data = 0;
        @(negedge clk);
        chk("R3 write0 clear", int'(secure), 0);
        // Same-cycle write and request, R10.
        sec_wr_data = 1;
        req_valid = 1; req_src = 0; req_op = 2'd0; req_page = '0;
        @(negedge clk);
        sec_wr_en = 0; req_valid = 0;
        chk("R10 old secure used", int'(req_grant), 1);
        chk("R3 set", int'(secure), 1);
        sec_wr_en = 1; sec_wr_data = 0;
        @(negedge clk);
        sec_wr_en = 0;
        chk("R3 write0 when set", int'(secure), 1);

        // Global erase keeps security until reset, R4.
        wait_window();
        do_req("R4 dbg global erase", 1, 2, 0, 1, 0);
        chk("R4 still secure", int'(secure), 1);
        repeat (20) @(negedge clk);
        chk("R4 sticky", int'(secure), 1);
        do_reset();
        chk("R4 reset clears", int'(secure), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule